// File: doc/BRIEF.md
# Vector Compare to Predicate Mask

This block turns a conditional-branch comparison into a per-element mask generator. A command names two source registers, the vector length assigned to each of them, the global vector length VL, a comparison code and a destination register. Each operand is either a vector held in consecutive integer registers or a scalar whose single register is reused for every element. The block walks elements 0 to VL-1 one per cycle and reads both operands through two register-file read ports. Each comparison result goes into the matching bit of a mask. The finished mask is written once, as a plain bitfield, to the destination integer register.

When neither operand is a vector, no mask is built. The block instead reads the two registers once and reports an ordinary taken/not-taken branch decision. Commands arrive on a valid/ready stream. While a command is in flight, `cmd_ready` stays low and the requester must hold `cmd_valid` and all command fields steady. The read ports are combinational: the address goes out and the data is expected back in the same cycle. The mask write port has no back-pressure: a register-file write is always taken.

Top module: `vec_cmp_mask`

## Requirements
- R1: `cmd_ready` is high only while the block is idle, and a command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. After a vector command with VL greater than zero is taken, `cmd_ready` is low until the cycle that carries its result.
- R2: An operand is a vector when its per-register length is greater than one. Element i of a vector operand is read from register (src + i) modulo 32. A scalar operand reads register src for every element.
- R3: The comparison code `cmd_op` selects one of these tests of operand A against operand B:
  - 0: A equal to B.
  - 1: A not equal to B.
  - 2: A less than B, signed.
  - 3: A greater than or equal to B, signed.
  - 4: A less than B, unsigned.
  - 5: A greater than or equal to B, unsigned.
  - 6 and 7: always false.
- R4: Bit i of the written mask equals the comparison result of element i, for every i below VL.
- R5: Mask bits at positions VL and above are written as zero. A vector command with VL of zero writes an all-zero mask one cycle after it is taken.
- R6: A VL larger than the register width (32) is treated as 32.
- R7: One element is compared per cycle. `wr_en` and `done` pulse high together for exactly the cycle VL+1 cycles after the command is taken. In that cycle `wr_addr` carries the destination register.
- R8: When both operands are scalar, no mask write occurs. Instead, `br_valid` pulses two cycles after the command is taken, with `br_taken` set to the comparison result.
- R9: In the cycle that carries a mask write or a branch result, `cmd_ready` is already high, so the next command can be taken in that same cycle.
- R10: Register indices wrap. A vector operand starting near the top of the register file continues from register 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_src_a | input | 5 | First source register |
| cmd_src_b | input | 5 | Second source register |
| cmd_len_a | input | 6 | Vector length assigned to the first source |
| cmd_len_b | input | 6 | Vector length assigned to the second source |
| cmd_vl | input | 6 | Global vector length |
| cmd_op | input | 3 | Comparison code |
| cmd_pdst | input | 5 | Destination register for the mask |
| rd_a_addr | output | 5 | Read port A address |
| rd_a_data | input | 32 | Read port A data (same cycle) |
| rd_b_addr | output | 5 | Read port B address |
| rd_b_data | input | 32 | Read port B data (same cycle) |
| wr_en | output | 1 | Mask write strobe |
| wr_addr | output | 5 | Mask write register |
| wr_data | output | 32 | Mask bitfield |
| done | output | 1 | Command finished (with mask write) |
| br_valid | output | 1 | Branch decision present |
| br_taken | output | 1 | Branch decision value |

## Verification
The delivery of one result, either a mask write or a branch decision, can share a cycle with the acceptance of the next command. This happens because `cmd_ready` rises in the result cycle. The bench provokes the overlap by presenting every new command in the very cycle where the previous result is observed. It also provokes it with back-to-back zero-length and scalar commands. It then judges each following command against its own independently computed mask and cycle count. This shows that the new accept neither disturbs the outgoing `wr_data`/`wr_addr` nor inherits mask bits from the previous command.

// File: rtl/vcm_pkg.sv
package vcm_pkg;

  typedef enum logic [2:0] {
    CMP_EQ  = 3'd0,
    CMP_NE  = 3'd1,
    CMP_LT  = 3'd2,
    CMP_GE  = 3'd3,
    CMP_LTU = 3'd4,
    CMP_GEU = 3'd5
  } cmp_op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_BRANCH = 2'd2
  } vcm_state_e;

endpackage

// File: rtl/vcm_compare.sv
module vcm_compare #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   op,
  output logic         hit
);
  import vcm_pkg::*;

  always_comb begin
    case (op)
      CMP_EQ:  hit = (a == b);
      CMP_NE:  hit = (a != b);
      CMP_LT:  hit = ($signed(a) <  $signed(b));
      CMP_GE:  hit = ($signed(a) >= $signed(b));
      CMP_LTU: hit = (a <  b);
      CMP_GEU: hit = (a >= b);
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/vcm_operand_addr.sv
module vcm_operand_addr #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] base,
  input  logic          is_vec,
  input  logic [AW-1:0] offset,
  output logic [AW-1:0] addr
);
  // register index wraps modulo 2**AW by plain truncating addition
  always_comb begin
    if (is_vec) addr = base + offset;
    else        addr = base;
  end

endmodule

// File: rtl/vcm_mask_acc.sv
module vcm_mask_acc #(
  parameter int MW = 32,
  localparam int IW = $clog2(MW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          set_en,
  input  logic [IW-1:0] pos,
  input  logic          bit_val,
  output logic [MW-1:0] mask
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
    end else if (clr) begin
      mask <= '0;
    end else if (set_en) begin
      mask[pos] <= bit_val;
    end
  end

endmodule

// File: rtl/vec_cmp_mask.sv
module vec_cmp_mask #(
  parameter int XLEN = 32,
  parameter int AW   = 5,
  localparam int VLW = $clog2(XLEN + 1),
  localparam int IW  = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [AW-1:0]   cmd_src_a,
  input  logic [AW-1:0]   cmd_src_b,
  input  logic [VLW-1:0]  cmd_len_a,
  input  logic [VLW-1:0]  cmd_len_b,
  input  logic [VLW-1:0]  cmd_vl,
  input  logic [2:0]      cmd_op,
  input  logic [AW-1:0]   cmd_pdst,
  output logic [AW-1:0]   rd_a_addr,
  input  logic [XLEN-1:0] rd_a_data,
  output logic [AW-1:0]   rd_b_addr,
  input  logic [XLEN-1:0] rd_b_data,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic [XLEN-1:0] wr_data,
  output logic            done,
  output logic            br_valid,
  output logic            br_taken
);
  import vcm_pkg::*;

  localparam logic [VLW-1:0] VL_MAX = VLW'(XLEN);

  vcm_state_e      state_q;
  logic [AW-1:0]   src_a_q, src_b_q, pdst_q;
  logic            vec_a_q, vec_b_q;
  logic [2:0]      op_q;
  logic [VLW-1:0]  vl_q, idx_q;
  logic [AW-1:0]   off_q;
  logic            wr_q, br_q, taken_q;

  logic            accept;
  logic            new_vec_a, new_vec_b;
  logic [VLW-1:0]  new_vl;
  logic            hit;
  logic            last_elem;
  logic            acc_set;

  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign new_vec_a = (cmd_len_a > VLW'(1));
  assign new_vec_b = (cmd_len_b > VLW'(1));
  assign new_vl    = (cmd_vl > VL_MAX) ? VL_MAX : cmd_vl;
  assign last_elem = (idx_q == vl_q - VLW'(1));
  assign acc_set   = (state_q == ST_RUN);

  // one address generator per read port
  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [AW-1:0] base;
    logic          vec;
    logic [AW-1:0] addr;
    assign base = (p == 0) ? src_a_q : src_b_q;
    assign vec  = (p == 0) ? vec_a_q : vec_b_q;
    vcm_operand_addr #(.AW(AW)) u_addr (
      .base   (base),
      .is_vec (vec),
      .offset (off_q),
      .addr   (addr)
    );
  end
  assign rd_a_addr = g_port[0].addr;
  assign rd_b_addr = g_port[1].addr;

  vcm_compare #(.W(XLEN)) u_cmp (
    .a   (rd_a_data),
    .b   (rd_b_data),
    .op  (op_q),
    .hit (hit)
  );

  vcm_mask_acc #(.MW(XLEN)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (accept),
    .set_en  (acc_set),
    .pos     (idx_q[IW-1:0]),
    .bit_val (hit),
    .mask    (wr_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      src_a_q <= '0;
      src_b_q <= '0;
      pdst_q  <= '0;
      vec_a_q <= 1'b0;
      vec_b_q <= 1'b0;
      op_q    <= '0;
      vl_q    <= '0;
      idx_q   <= '0;
      off_q   <= '0;
      wr_q    <= 1'b0;
      br_q    <= 1'b0;
      taken_q <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      br_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            src_a_q <= cmd_src_a;
            src_b_q <= cmd_src_b;
            pdst_q  <= cmd_pdst;
            vec_a_q <= new_vec_a;
            vec_b_q <= new_vec_b;
            op_q    <= cmd_op;
            vl_q    <= new_vl;
            idx_q   <= '0;
            off_q   <= '0;
            if (!new_vec_a && !new_vec_b) begin
              state_q <= ST_BRANCH;
            end else if (new_vl == '0) begin
              wr_q <= 1'b1;
            end else begin
              state_q <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (last_elem) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b1;
          end else begin
            idx_q <= idx_q + VLW'(1);
            off_q <= off_q + AW'(1);
          end
        end
        ST_BRANCH: begin
          state_q <= ST_IDLE;
          br_q    <= 1'b1;
          taken_q <= hit;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_en    = wr_q;
  assign done     = wr_q;
  assign wr_addr  = pdst_q;
  assign br_valid = br_q;
  assign br_taken = taken_q;

endmodule

// File: rtl/vec_cmp_mask_chk.sv
module vec_cmp_mask_chk #(
  parameter int XLEN = 32,
  parameter int AW   = 5,
  localparam int VLW = $clog2(XLEN + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [VLW-1:0]  cmd_len_a,
  input logic [VLW-1:0]  cmd_len_b,
  input logic [VLW-1:0]  cmd_vl,
  input logic [AW-1:0]   cmd_pdst,
  input logic            wr_en,
  input logic [AW-1:0]   wr_addr,
  input logic [XLEN-1:0] wr_data,
  input logic            br_valid
);
  logic           acc_c, vec_c;
  logic [VLW-1:0] vl_c;
  logic [VLW-1:0] vl_seen;
  logic [AW-1:0]  pdst_seen;

  assign acc_c = cmd_valid && cmd_ready;
  assign vec_c = (cmd_len_a > VLW'(1)) || (cmd_len_b > VLW'(1));
  assign vl_c  = (cmd_vl > VLW'(XLEN)) ? VLW'(XLEN) : cmd_vl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_seen   <= VLW'(XLEN);
      pdst_seen <= '0;
    end else if (acc_c) begin
      vl_seen   <= vl_c;
      pdst_seen <= cmd_pdst;
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_c && vec_c && vl_c != '0) |=> !cmd_ready); // R1

  AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_data >> vl_seen) == '0)); // R5

  AST_ZERO_VL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_c && vec_c && vl_c == '0) |=> (wr_en && wr_data == '0)); // R5

  AST_WR_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr == pdst_seen)); // R7

  AST_BRANCH_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_c && !vec_c) |=> ##1 (br_valid && !wr_en)); // R8

  AST_BRANCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> !br_valid); // R8

  AST_READY_AT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || br_valid) |-> cmd_ready); // R9

endmodule

bind vec_cmp_mask vec_cmp_mask_chk #(.XLEN(XLEN), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_len_a (cmd_len_a),
  .cmd_len_b (cmd_len_b),
  .cmd_vl    (cmd_vl),
  .cmd_pdst  (cmd_pdst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .br_valid  (br_valid)
);

// File: tb/vec_cmp_mask_tb.sv
module vec_cmp_mask_tb;
  localparam int XLEN = 32;
  localparam int AW   = 5;
  localparam int VLW  = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cmd_valid = 1'b0;
  logic            cmd_ready;
  logic [AW-1:0]   cmd_src_a = '0, cmd_src_b = '0, cmd_pdst = '0;
  logic [VLW-1:0]  cmd_len_a = '0, cmd_len_b = '0, cmd_vl = '0;
  logic [2:0]      cmd_op = '0;
  logic [AW-1:0]   rd_a_addr, rd_b_addr, wr_addr;
  logic [XLEN-1:0] rd_a_data, rd_b_data, wr_data;
  logic            wr_en, done, br_valid, br_taken;

  logic [XLEN-1:0] rf [32];
  int total = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign rd_a_data = rf[rd_a_addr];
  assign rd_b_data = rf[rd_b_addr];

  vec_cmp_mask #(.XLEN(XLEN), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b), .cmd_len_a(cmd_len_a),
    .cmd_len_b(cmd_len_b), .cmd_vl(cmd_vl), .cmd_op(cmd_op), .cmd_pdst(cmd_pdst),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data), .rd_b_addr(rd_b_addr),
    .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .br_valid(br_valid), .br_taken(br_taken)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // R3: 0 eq, 1 ne, 2 lt signed, 3 ge signed, 4 ltu, 5 geu, 6/7 false
  function automatic bit cmp_ref(input int op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      0: return a == b;
      1: return a != b;
      2: return $signed(a) < $signed(b);
      3: return $signed(a) >= $signed(b);
      4: return a < b;
      5: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int clamp_vl(input int vl);
    return (vl > XLEN) ? XLEN : vl;
  endfunction

  // R2/R4/R5/R10 reference mask
  function automatic logic [31:0] mask_ref(input int sa, input int sb, input int la,
                                           input int lb, input int vl, input int op);
    logic [31:0] m = '0;
    for (int i = 0; i < clamp_vl(vl); i++) begin
      int ia = (la > 1) ? ((sa + i) % 32) : sa;
      int ib = (lb > 1) ? ((sb + i) % 32) : sb;
      m[i] = cmp_ref(op, rf[ia], rf[ib]);
    end
    return m;
  endfunction

  // called at a negedge with the block idle; returns at the result negedge
  task automatic issue(input int sa, input int sb, input int la, input int lb,
                       input int vl, input int op, input int pd);
    bit is_vec = (la > 1) || (lb > 1);
    int exp_k = is_vec ? (clamp_vl(vl) == 0 ? 1 : clamp_vl(vl) + 1) : 2;
    logic [31:0] exp_m = mask_ref(sa, sb, la, lb, vl, op);
    bit exp_t = cmp_ref(op, rf[sa], rf[sb]);
    int k = 0;
    bit seen = 0;
    check(cmd_ready == 1'b1, "R9", "ready at issue", 32'(cmd_ready), 32'd1);
    cmd_src_a = AW'(sa); cmd_src_b = AW'(sb); cmd_len_a = VLW'(la);
    cmd_len_b = VLW'(lb); cmd_vl = VLW'(vl); cmd_op = 3'(op); cmd_pdst = AW'(pd);
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    k = 1;
    if (is_vec && clamp_vl(vl) > 0)
      check(cmd_ready == 1'b0, "R1", "ready low while busy", 32'(cmd_ready), 32'd0);
    while (!seen && k < 80) begin
      if (wr_en || br_valid) seen = 1;
      else begin
        @(negedge clk);
        k++;
      end
    end
    check(k == exp_k, "R7", "result cycle", 32'(k), 32'(exp_k));
    if (is_vec) begin
      check(wr_en && done && !br_valid, "R8", "mask write not branch",
            {29'd0, wr_en, done, br_valid}, 32'd6);
      check(wr_data == exp_m, "R4", "mask value", wr_data, exp_m);
      check(wr_addr == AW'(pd), "R7", "write address", 32'(wr_addr), 32'(pd));
    end else begin
      check(br_valid && !wr_en, "R8", "branch not write", {30'd0, br_valid, wr_en}, 32'd2);
      check(br_taken == exp_t, "R8", "branch taken", 32'(br_taken), 32'(exp_t));
    end
    check(cmd_ready == 1'b1, "R9", "ready in result cycle", 32'(cmd_ready), 32'd1);
  endtask

  function automatic logic [31:0] rnd_val();
    int s = $urandom % 4;
    case (s)
      0: return 32'($urandom % 4);
      1: return 32'h8000_0000 | 32'($urandom % 4);
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL R7 watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int r = 0; r < 32; r++) rf[r] = rnd_val();
    repeat (3) @(negedge clk);
    check(cmd_ready == 1'b1 && !wr_en && !br_valid && !done, "R1", "reset state",
          {28'd0, cmd_ready, wr_en, br_valid, done}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: each comparison code on a vector-vector pair
    for (int r = 0; r < 8; r++) begin rf[r] = 32'(r); rf[8 + r] = 32'(3); end
    rf[1] = 32'hFFFF_FFFF;
    for (int op = 0; op < 8; op++) issue(0, 8, 8, 8, 8, op, 20 + op);
    // R2: scalar broadcast on either side
    issue(0, 8, 8, 1, 8, 2, 3);
    issue(3, 0, 0, 8, 8, 4, 4);
    // R5: zero VL, back to back, then R6 clamp
    issue(0, 8, 4, 4, 0, 0, 5);
    issue(0, 8, 4, 4, 0, 1, 6);
    issue(0, 8, 40, 40, 40, 5, 7);
    issue(2, 9, 2, 2, 63, 1, 8);
    // R10: wrap past register 31
    issue(29, 5, 6, 6, 6, 1, 9);
    issue(30, 0, 3, 1, 5, 3, 10);
    // R8: scalar-scalar branch taken and not taken, back to back
    rf[12] = 32'd7; rf[13] = 32'd7;
    issue(12, 13, 1, 0, 9, 0, 11);
    issue(12, 13, 0, 1, 9, 1, 11);
    issue(12, 13, 1, 1, 0, 6, 11);
    // R4: single-element and full-width
    issue(4, 4, 2, 2, 1, 0, 12);
    issue(0, 0, 32, 32, 32, 3, 13);

    // constrained random mix
    for (int n = 0; n < 120; n++) begin
      int la = ($urandom % 3 == 0) ? int'($urandom % 2) : int'($urandom % 40);
      int lb = ($urandom % 3 == 0) ? int'($urandom % 2) : int'($urandom % 40);
      int vl = ($urandom % 8 == 0) ? int'($urandom % 64) : int'($urandom % 33);
      if (n % 10 == 0) for (int r = 0; r < 32; r++) rf[r] = rnd_val();
      issue(int'($urandom % 32), int'($urandom % 32), la, lb, vl,
            int'($urandom % 8), int'($urandom % 32));
    end

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule